// File: doc/BRIEF.md
# Coherent Split 64-bit Time Reader

This block reads a free-running 64-bit time counter that is only reachable as two 32-bit registers, one for the low word and one for the high word. It returns a 64-bit value that is consistent even when the low word overflows into the high word between the individual accesses. A single `start_i` pulse launches a sequence of 32-bit reads over a simple request/acknowledge port. The block reads the low word, then the high word, then the low word again. If that third read shows that the low word has wrapped, the block reads the low and high words once more and builds the result from that second pair.

Two one-cycle strobes mark the sampling of the low word. One marks the start of the bracketed low read and the other marks its completion, so that surrounding logic can capture a system timestamp on each side of the sample. Completion is signalled by a one-cycle `done_o` pulse. An error reported by the bus on any read ends the sequence at once, and `err_o` is raised in the same cycle as `done_o`.

Top module: `tsplit_reader`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rd_req_o`, `pre_stb_o`, `post_stb_o`, `done_o` and `err_o` are 0 and `time_o` is all zeros.
- R2: Reads are issued one at a time. `rd_req_o` stays high with a stable `rd_addr_o` until a cycle with `rd_ack_i` high, which completes that read. The order is low word (`rd_addr_o` = LO_ADDR), high word (`rd_addr_o` = HI_ADDR), then low word.
- R3: If the third read returns a low value equal to or greater than the first low value, the result is `{high, first low}`, with the high word in bits 63:32 of `time_o`.
- R4: If the third read returns a low value strictly less than the first, the block reads the low word and then the high word again, and the result is `{second high, retry low}`.
- R5: A sequence performs at most one retry, so it never issues more than five reads.
- R6: `pre_stb_o` pulses for one cycle in the first cycle of the first low read and in the first cycle of the retry low read. It does not pulse for the comparison low read.
- R7: `post_stb_o` pulses for one cycle in the cycle after a bracketed low read (first or retry) is acknowledged without error.
- R8: `done_o` is a one-cycle pulse in the cycle after the final acknowledge. From that cycle on, `time_o` holds the result until the next successful sequence.
- R9: An acknowledge with `rd_err_i` high ends the sequence. In the next cycle `done_o` and `err_o` are both high, no further read is requested, and `time_o` keeps its previous value.
- R10: A `start_i` pulse while a sequence is in progress is ignored. It adds no reads and no extra `done_o`.
- R11: `err_o` is high only in a cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a coherent read (honoured only when idle) |
| rd_req_o | output | 1 | Read request, held until acknowledged |
| rd_addr_o | output | ADDR_W | Register address of the current read |
| rd_ack_i | input | 1 | Read acknowledge; completes the current read |
| rd_err_i | input | 1 | Bus error, qualified by rd_ack_i |
| rd_data_i | input | 32 | Read data, qualified by rd_ack_i |
| pre_stb_o | output | 1 | Pulse marking the start of a bracketed low read |
| post_stb_o | output | 1 | Pulse marking completion of a bracketed low read |
| done_o | output | 1 | Sequence finished (success or error) |
| err_o | output | 1 | Sequence aborted by a bus error |
| time_o | output | 64 | Last coherent time value |

## Verification
The assertions assume that the bus slave raises `rd_ack_i` only while `rd_req_o` is high, and that `rd_err_i` and `rd_data_i` mean something only in acknowledge cycles. The bench slave keeps to this rule. It acknowledges a held request after a chosen latency, drops the acknowledge for one cycle after each completed read, and drives a synthetic counter that advances by a fixed step on every access. The sweep places the low word from zero to seven counts below its wrap point and uses several steps and latencies, including a frozen counter. This puts the overflow before, between and after each read, and covers equal low values.

// File: rtl/tsplit_pkg.sv
package tsplit_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned TIME_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_LO_FIRST = 3'd1,
        ST_HI_FIRST = 3'd2,
        ST_LO_CHECK = 3'd3,
        ST_LO_RETRY = 3'd4,
        ST_HI_RETRY = 3'd5
    } rd_state_e;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } time_pair_t;

    function automatic logic reads_high(input rd_state_e st);
        return (st == ST_HI_FIRST) || (st == ST_HI_RETRY);
    endfunction

    function automatic logic bracketed_low(input rd_state_e st);
        return (st == ST_LO_FIRST) || (st == ST_LO_RETRY);
    endfunction

    function automatic logic low_wrapped(input word_t first_lo, input word_t check_lo);
        return check_lo < first_lo;
    endfunction

endpackage

// File: rtl/tsplit_seq.sv
module tsplit_seq
    import tsplit_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  logic      ack_i,
    input  logic      err_i,
    input  logic      wrapped_i,
    output rd_state_e state_o,
    output logic      enter_low_o,
    output logic      low_ok_o,
    output logic      finish_o,
    output logic      abort_o
);

    rd_state_e state_q, state_d;
    logic      good_ack;

    assign good_ack = ack_i && !err_i && (state_q != ST_IDLE);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_LO_FIRST;
            ST_LO_FIRST: if (ack_i) state_d = err_i ? ST_IDLE : ST_HI_FIRST;
            ST_HI_FIRST: if (ack_i) state_d = err_i ? ST_IDLE : ST_LO_CHECK;
            ST_LO_CHECK: if (ack_i) state_d = (!err_i && wrapped_i) ? ST_LO_RETRY : ST_IDLE;
            ST_LO_RETRY: if (ack_i) state_d = err_i ? ST_IDLE : ST_HI_RETRY;
            ST_HI_RETRY: if (ack_i) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state_o     = state_q;
    assign enter_low_o = ((state_q == ST_IDLE) && start_i)
                      || ((state_q == ST_LO_CHECK) && good_ack && wrapped_i);
    assign low_ok_o    = good_ack && bracketed_low(state_q);
    assign finish_o    = good_ack && (((state_q == ST_LO_CHECK) && !wrapped_i)
                                      || (state_q == ST_HI_RETRY));
    assign abort_o     = ack_i && err_i && (state_q != ST_IDLE);

endmodule

// File: rtl/tsplit_capture.sv
module tsplit_capture
    import tsplit_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  rd_state_e         state_i,
    input  logic              ack_i,
    input  logic              err_i,
    input  word_t             data_i,
    input  logic              finish_i,
    input  logic              abort_i,
    output logic              wrapped_o,
    output logic              done_o,
    output logic              err_o,
    output logic [TIME_W-1:0] time_o
);

    word_t      lo_q, hi_q;
    time_pair_t result_q, result_d;
    logic       done_q, err_q;
    logic       take;

    assign take      = ack_i && !err_i;
    assign wrapped_o = low_wrapped(lo_q, data_i);

    always_comb begin
        result_d.lo = lo_q;
        result_d.hi = (state_i == ST_HI_RETRY) ? data_i : hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q     <= '0;
            hi_q     <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= finish_i || abort_i;
            err_q  <= abort_i;
            if (take && bracketed_low(state_i)) lo_q <= data_i;
            if (take && reads_high(state_i))    hi_q <= data_i;
            if (finish_i)                       result_q <= result_d;
        end
    end

    assign done_o = done_q;
    assign err_o  = err_q;
    assign time_o = result_q;

endmodule

// File: rtl/tsplit_strobe.sv
module tsplit_strobe (
    input  logic clk,
    input  logic rst,
    input  logic enter_low_i,
    input  logic low_ok_i,
    output logic pre_o,
    output logic post_o
);

    logic pre_q, post_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= 1'b0;
            post_q <= 1'b0;
        end else begin
            pre_q  <= enter_low_i;
            post_q <= low_ok_i;
        end
    end

    assign pre_o  = pre_q;
    assign post_o = post_q;

endmodule

// File: rtl/tsplit_reader.sv
module tsplit_reader
    import tsplit_pkg::*;
#(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned LO_ADDR = 0,
    parameter int unsigned HI_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_ack_i,
    input  logic              rd_err_i,
    input  logic [31:0]       rd_data_i,
    output logic              pre_stb_o,
    output logic              post_stb_o,
    output logic              done_o,
    output logic              err_o,
    output logic [63:0]       time_o
);

    localparam logic [ADDR_W-1:0] LO_SEL = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] HI_SEL = ADDR_W'(HI_ADDR);

    rd_state_e state;
    logic      enter_low, low_ok, finish, abort_rd, wrapped;

    tsplit_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .ack_i       (rd_ack_i),
        .err_i       (rd_err_i),
        .wrapped_i   (wrapped),
        .state_o     (state),
        .enter_low_o (enter_low),
        .low_ok_o    (low_ok),
        .finish_o    (finish),
        .abort_o     (abort_rd)
    );

    tsplit_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .state_i   (state),
        .ack_i     (rd_ack_i),
        .err_i     (rd_err_i),
        .data_i    (rd_data_i),
        .finish_i  (finish),
        .abort_i   (abort_rd),
        .wrapped_o (wrapped),
        .done_o    (done_o),
        .err_o     (err_o),
        .time_o    (time_o)
    );

    tsplit_strobe u_stb (
        .clk         (clk),
        .rst         (rst),
        .enter_low_i (enter_low),
        .low_ok_i    (low_ok),
        .pre_o       (pre_stb_o),
        .post_o      (post_stb_o)
    );

    assign rd_req_o  = (state != ST_IDLE);
    assign rd_addr_o = reads_high(state) ? HI_SEL : LO_SEL;

endmodule

// File: rtl/tsplit_reader_chk.sv
module tsplit_reader_chk #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned LO_ADDR = 0
) (
    input logic              clk,
    input logic              rst,
    input logic              start_i,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_ack_i,
    input logic              rd_err_i,
    input logic              pre_stb_o,
    input logic              post_stb_o,
    input logic              done_o,
    input logic              err_o,
    input logic [63:0]       time_o
);

    localparam logic [ADDR_W-1:0] LO_SEL = ADDR_W'(LO_ADDR);

    logic [2:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (rst || done_o)   pre_cnt <= '0;
        else if (pre_stb_o)  pre_cnt <= pre_cnt + 3'd1;
    end

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o));

    assert_retry_limit_R5: assert property (@(posedge clk) disable iff (rst)
        pre_cnt <= 3'd2);

    assert_pre_low_R6: assert property (@(posedge clk) disable iff (rst)
        pre_stb_o |-> rd_req_o && (rd_addr_o == LO_SEL));

    assert_post_after_low_R7: assert property (@(posedge clk) disable iff (rst)
        post_stb_o |-> $past(rd_req_o && rd_ack_i && !rd_err_i && (rd_addr_o == LO_SEL)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !rd_req_o);

    assert_time_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> $stable(time_o));

    assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && rd_ack_i && rd_err_i |=> done_o && err_o && !rd_req_o);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        rd_req_o && start_i && !rd_ack_i |=> !pre_stb_o);

    assert_err_with_done_R11: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

endmodule

bind tsplit_reader tsplit_reader_chk #(
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .rd_req_o   (rd_req_o),
    .rd_addr_o  (rd_addr_o),
    .rd_ack_i   (rd_ack_i),
    .rd_err_i   (rd_err_i),
    .pre_stb_o  (pre_stb_o),
    .post_stb_o (post_stb_o),
    .done_o     (done_o),
    .err_o      (err_o),
    .time_o     (time_o)
);

// File: tb/tsplit_reader_test.sv
module tsplit_reader_test;

    localparam int ADDR_W  = 4;
    localparam int LO_ADDR = 0;
    localparam int HI_ADDR = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start_i = 1'b0;
    logic              rd_req_o;
    logic [ADDR_W-1:0] rd_addr_o;
    logic              rd_ack_i = 1'b0;
    logic              rd_err_i = 1'b0;
    logic [31:0]       rd_data_i = '0;
    logic              pre_stb_o, post_stb_o, done_o, err_o;
    logic [63:0]       time_o;

    tsplit_reader #(.ADDR_W(ADDR_W), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)) uut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
        .rd_ack_i(rd_ack_i), .rd_err_i(rd_err_i), .rd_data_i(rd_data_i),
        .pre_stb_o(pre_stb_o), .post_stb_o(post_stb_o),
        .done_o(done_o), .err_o(err_o), .time_o(time_o)
    );

    always #2.5 clk = ~clk;

    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 0;

    // slave and counter model
    logic [63:0] base_v, step_v;
    int          lat     = 0;
    int          wait_c  = 0;
    int          acc_idx = 0;
    int          err_at  = -1;
    string       evlog   = "";
    int          done_cnt = 0;
    bit          last_err = 0;

    function automatic logic [63:0] tval(input int k);
        return base_v + 64'(k) * step_v;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (pre_stb_o)  evlog = {evlog, "p"};
            if (post_stb_o) evlog = {evlog, "q"};
            if (done_o) begin
                done_cnt++;
                last_err = err_o;
            end
            if (rd_ack_i) begin
                rd_ack_i = 1'b0;
                rd_err_i = 1'b0;
                wait_c   = 0;
            end else if (rd_req_o) begin
                if (wait_c >= lat) begin
                    logic [63:0] v;
                    v = tval(acc_idx);
                    rd_data_i = (rd_addr_o == ADDR_W'(LO_ADDR)) ? v[31:0] : v[63:32];
                    evlog = {evlog, (rd_addr_o == ADDR_W'(LO_ADDR)) ? "L" : "H"};
                    rd_err_i = (acc_idx == err_at);
                    rd_ack_i = 1'b1;
                    acc_idx++;
                end else begin
                    wait_c++;
                end
            end
        end
    end

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic checkstr(input string req, input string what,
                            input string act, input string exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, exp);
        end
    endtask

    logic [63:0] prev_good = '0;

    task automatic run(input logic [63:0] base, input logic [63:0] step, input int latency,
                       input int err_idx, input bit extra_start,
                       input string exp_log, input logic [63:0] exp_time,
                       input bit exp_err, input string req);
        int d0;
        base_v = base; step_v = step; lat = latency; err_at = err_idx;
        acc_idx = 0; evlog = ""; wait_c = 0;
        d0 = done_cnt;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        if (extra_start) begin
            @(negedge clk); start_i = 1'b1;   // R10 start while busy
            @(negedge clk); start_i = 1'b0;
        end
        for (int i = 0; i < 200 && done_cnt == d0; i++) @(negedge clk);
        repeat (10) @(negedge clk);
        check64(req, "done count", 64'(done_cnt - d0), 64'd1);
        checkstr(req, "event order", evlog, exp_log);
        check64("R9/R11", "error flag", 64'(last_err), 64'(exp_err));
        check64(req, "time value (R8 held)", time_o, exp_time);
        check64("R2", "request idle after done", 64'(rd_req_o), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check64("R1", "req in reset", 64'(rd_req_o), 64'd0);
        check64("R1", "done/err/strobes in reset",
                64'({done_o, err_o, pre_stb_o, post_stb_o}), 64'd0);
        check64("R1", "time in reset", time_o, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check64("R1", "outputs after reset",
                64'({rd_req_o, done_o, err_o, pre_stb_o, post_stb_o}), 64'd0);

        // R3 R4 R5 R6 R7 sweep across wrap positions, steps and latencies
        for (int off = 0; off < 8; off++) begin
            for (int st = 0; st < 4; st++) begin
                for (int l = 0; l < 3; l++) begin
                    logic [63:0] b, v0, v1, v2, v3, v4, et;
                    bit          wr;
                    b  = {32'h0000_0012 + 32'(off), 32'hFFFF_FFFF - 32'(off)};
                    v0 = b; v1 = b + 64'(st); v2 = b + 64'(2*st);
                    v3 = b + 64'(3*st); v4 = b + 64'(4*st);
                    wr = v2[31:0] < v0[31:0];
                    et = wr ? {v4[63:32], v3[31:0]} : {v1[63:32], v0[31:0]};
                    run(b, 64'(st), l, -1, 1'b0,
                        wr ? "pLqHLpLqH" : "pLqHL", et, 1'b0,
                        wr ? "R4_R5_R6_R7" : "R3_R6_R7");
                    prev_good = et;
                end
            end
        end

        // R3 low far from the wrap point, frozen counter (equal lows)
        run(64'h0123_4567_89AB_CDEF, 64'd0, 1, -1, 1'b0, "pLqHL",
            64'h0123_4567_89AB_CDEF, 1'b0, "R3");
        prev_good = 64'h0123_4567_89AB_CDEF;

        // R10 second start while busy
        run(64'h0000_0100_0000_1000, 64'd5, 0, -1, 1'b1, "pLqHL",
            64'h0000_0100_0000_1000, 1'b0, "R10");
        prev_good = 64'h0000_0100_0000_1000;

        // R9 bus error at each read position (wrapping setup: low 0xFFFFFFFE, step 1)
        run(64'h0000_0020_FFFF_FFFE, 64'd1, 1, 0, 1'b0, "pL",        prev_good, 1'b1, "R9");
        run(64'h0000_0020_FFFF_FFFE, 64'd1, 1, 1, 1'b0, "pLqH",      prev_good, 1'b1, "R9");
        run(64'h0000_0020_FFFF_FFFE, 64'd1, 1, 2, 1'b0, "pLqHL",     prev_good, 1'b1, "R9");
        run(64'h0000_0020_FFFF_FFFE, 64'd1, 1, 3, 1'b0, "pLqHLpL",   prev_good, 1'b1, "R9");
        run(64'h0000_0020_FFFF_FFFE, 64'd1, 1, 4, 1'b0, "pLqHLpLqH", prev_good, 1'b1, "R9");

        // R9 recovery: a clean sequence after an error clears the flag
        run(64'h0000_0030_0000_0040, 64'd2, 2, -1, 1'b0, "pLqHL",
            64'h0000_0030_0000_0040, 1'b0, "R9_R11");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule